// File: doc/BRIEF.md
# Overcurrent Shutdown Latch for a Three-Leg Inverter

This block collects the overcurrent trip flags of the three inverter legs and the sensed level of one shared shutdown/fault line, and decides whether the gate drivers may conduct. The line is wired-OR. An external controller can pull it low, and this block can also pull it low through an open-drain enable. An external RC network pulls it back up. The analog comparators, the RC network and the level sensing sit outside the block. The line level arrives as two synchronized flags, one set above the upper threshold and one set below the lower threshold, and together they give the input its hysteresis.

A trip on any leg removes every gate command in the same cycle, through a combinational path that does not wait for the line to discharge. On the next edge the block enters a pulling state and turns the open-drain enable on. It holds the pull-down until the line is seen below the lower threshold. It then releases the line and stays in a recovering state, with the drivers still off, until the line is seen above the upper threshold. The external RC time constant therefore stretches the disable time. Out of reset the block starts in the recovering state. A sticky per-leg record shows which legs have tripped, and a write-one-to-clear strobe clears it.

Top module: `sd_fault_latch`

## Requirements
- R1: While rst_ni is low and in the cycle after it rises, pd_en_o is 0, every gate output is 0 and trip_seen_o is all zeros.
- R2: When any bit of trip_i is 1, every bit of gate_hi_o and gate_lo_o is 0 in that same cycle, whatever the commands and the state.
- R3: A clock edge that samples any trip_i bit high makes pd_en_o 1 in the following cycle.
- R4: Once pd_en_o is 1, it stays 1 until an edge samples pin_below_lower_i high with no trip present. After that edge pd_en_o is 0 and the gates stay off.
- R5: With pd_en_o low after a shutdown, or after reset, the gates stay off until an edge samples pin_above_upper_i high with no trip present. From the next cycle the gates follow their commands.
- R6: A trip sampled while the block is recovering (pull-down released, gates off) turns pd_en_o back on in the next cycle.
- R7: In the running state, pin_below_lower_i high forces all gates to 0 in that same cycle. The edge that samples it moves the block to recovering without turning on pd_en_o.
- R8: In the running state, with no trip and pin_below_lower_i low, gate_hi_o[i] equals gate_hi_cmd_i[i] and gate_lo_o[i] equals gate_lo_cmd_i[i] for each leg i, in the same cycle.
- R9: An edge that samples trip_i[i] high sets trip_seen_o[i]. Bit i stays set until it is cleared.
- R10: An edge that samples trip_clr_i[i] high clears trip_seen_o[i], unless trip_i[i] is high at that same edge, in which case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 3 | Synchronized overcurrent trip flag per leg, bit i = leg i |
| pin_above_upper_i | input | 1 | Shutdown line sensed above upper threshold |
| pin_below_lower_i | input | 1 | Shutdown line sensed below lower threshold |
| gate_hi_cmd_i | input | 3 | High-side gate command per leg |
| gate_lo_cmd_i | input | 3 | Low-side gate command per leg |
| trip_clr_i | input | 3 | Write-one-to-clear strobe for trip_seen_o |
| gate_hi_o | output | 3 | Gated high-side drive per leg |
| gate_lo_o | output | 3 | Gated low-side drive per leg |
| pd_en_o | output | 1 | Open-drain pull-down enable for the shutdown line |
| trip_seen_o | output | 3 | Sticky record of tripped legs |

## Verification
A wrong internal state shows at the ports within one cycle. If the block is stuck running, the gates follow their commands while the model expects them off. If it is stuck pulling or recovering, the gates stay off when they should conduct. An early or missing release shows as pd_en_o differing from the expected value in the cycle after the deciding edge. The gate outputs are compared before every edge and pd_en_o after every edge, so a bad transition shows up in the first cycle after it happens. A lost or wrongly cleared trip record shows on trip_seen_o after the same edge.

// File: rtl/sd_fault_pkg.sv
package sd_fault_pkg;
  typedef enum logic [1:0] {
    SD_RUN     = 2'd0,
    SD_PULL    = 2'd1,
    SD_RECOVER = 2'd2
  } sd_state_e;
endpackage

// File: rtl/sd_fault_fsm.sv
module sd_fault_fsm
  import sd_fault_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      trip_any_i,
  input  logic      above_upper_i,
  input  logic      below_lower_i,
  output sd_state_e state_o,
  output logic      pd_en_o,
  output logic      drv_ok_o
);
  sd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (trip_any_i) begin
      state_d = SD_PULL;
    end else begin
      unique case (state_q)
        SD_RUN:     if (below_lower_i) state_d = SD_RECOVER;
        SD_PULL:    if (below_lower_i) state_d = SD_RECOVER;
        SD_RECOVER: if (above_upper_i) state_d = SD_RUN;
        default:    state_d = SD_RECOVER;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SD_RECOVER;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign pd_en_o  = (state_q == SD_PULL);
  // direct path: trip or external shutdown kill drive in the same cycle
  assign drv_ok_o = (state_q == SD_RUN) && !trip_any_i && !below_lower_i;

  p_pull_after_trip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_any_i |=> pd_en_o);

  p_hold_pull_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_en_o && !below_lower_i) |=> pd_en_o);

  p_stay_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SD_RECOVER && !above_upper_i && !trip_any_i) |=> !drv_ok_o);

  p_ext_sd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SD_RUN && below_lower_i && !trip_any_i) |=> (state_q == SD_RECOVER));
endmodule

// File: rtl/sd_leg_gate.sv
module sd_leg_gate (
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic drv_ok_i,
  output logic hi_o,
  output logic lo_o
);
  assign hi_o = hi_cmd_i && drv_ok_i;
  assign lo_o = lo_cmd_i && drv_ok_i;
endmodule

// File: rtl/sd_trip_record.sv
module sd_trip_record #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] seen_o
);
  logic [WIDTH-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= (seen_q & ~clr_i) | set_i; // set wins over clear
  end

  assign seen_o = seen_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chk
    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q[g] && !clr_i[g]) |=> seen_q[g]);
    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> seen_q[g]);
  end
endmodule

// File: rtl/sd_fault_latch.sv
module sd_fault_latch
  import sd_fault_pkg::*;
#(
  parameter int unsigned NUM_LEGS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_LEGS-1:0] trip_i,
  input  logic                pin_above_upper_i,
  input  logic                pin_below_lower_i,
  input  logic [NUM_LEGS-1:0] gate_hi_cmd_i,
  input  logic [NUM_LEGS-1:0] gate_lo_cmd_i,
  input  logic [NUM_LEGS-1:0] trip_clr_i,
  output logic [NUM_LEGS-1:0] gate_hi_o,
  output logic [NUM_LEGS-1:0] gate_lo_o,
  output logic                pd_en_o,
  output logic [NUM_LEGS-1:0] trip_seen_o
);
  sd_state_e state;
  logic      drv_ok;
  logic      trip_any;

  assign trip_any = |trip_i;

  sd_fault_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trip_any_i    (trip_any),
    .above_upper_i (pin_above_upper_i),
    .below_lower_i (pin_below_lower_i),
    .state_o       (state),
    .pd_en_o       (pd_en_o),
    .drv_ok_o      (drv_ok)
  );

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    sd_leg_gate u_gate (
      .hi_cmd_i (gate_hi_cmd_i[l]),
      .lo_cmd_i (gate_lo_cmd_i[l]),
      .drv_ok_i (drv_ok),
      .hi_o     (gate_hi_o[l]),
      .lo_o     (gate_lo_o[l])
    );
  end

  sd_trip_record #(.WIDTH(NUM_LEGS)) u_rec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trip_i),
    .clr_i  (trip_clr_i),
    .seen_o (trip_seen_o)
  );

  p_trip_kills_gates_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trip_i) |-> ((gate_hi_o | gate_lo_o) == '0));

  p_no_drive_while_pull_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_en_o |-> ((gate_hi_o | gate_lo_o) == '0));
endmodule

// File: tb/sim_sd_fault_latch.sv
module sim_sd_fault_latch;
  localparam int L = 3;
  localparam int M_RUN = 0, M_PULL = 1, M_REC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] trip = '0, hi_cmd = '0, lo_cmd = '0, clr = '0;
  logic above = 1'b0, below = 1'b0;
  logic [L-1:0] hi_o, lo_o, seen_o;
  logic pd_o;

  int checks = 0, errors = 0;
  int m_st = M_REC;
  logic [L-1:0] m_seen = '0;

  always #2.5 clk = ~clk;

  sd_fault_latch #(.NUM_LEGS(L)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip),
    .pin_above_upper_i(above), .pin_below_lower_i(below),
    .gate_hi_cmd_i(hi_cmd), .gate_lo_cmd_i(lo_cmd), .trip_clr_i(clr),
    .gate_hi_o(hi_o), .gate_lo_o(lo_o), .pd_en_o(pd_o), .trip_seen_o(seen_o)
  );

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_st(int st, logic t, logic a, logic b);
    if (t) return M_PULL;
    case (st)
      M_RUN:   return b ? M_REC : M_RUN;
      M_PULL:  return b ? M_REC : M_PULL;
      default: return a ? M_RUN : M_REC;
    endcase
  endfunction

  function automatic logic drv_exp(int st, logic t, logic b);
    return (st == M_RUN) && !t && !b;
  endfunction

  function automatic string gate_tag(int st, logic t, logic b);
    if (t) return "R2 gates off on trip";
    if (st == M_RUN && b) return "R7 external shutdown";
    if (st == M_RUN) return "R8 gates follow commands";
    if (st == M_PULL) return "R4 gates off while pulling";
    return "R5 gates off while recovering";
  endfunction

  // drive at negedge, check combinational outputs, clock model at posedge
  task automatic step(input logic [L-1:0] t, input logic a, input logic b,
                      input logic [L-1:0] h, input logic [L-1:0] lw, input logic [L-1:0] c);
    logic d;
    int prev;
    @(negedge clk);
    trip = t; above = a; below = b; hi_cmd = h; lo_cmd = lw; clr = c;
    #1;
    d = drv_exp(m_st, |t, b);
    chk(gate_tag(m_st, |t, b), hi_o, h & {L{d}});
    chk(gate_tag(m_st, |t, b), lo_o, lw & {L{d}});
    @(posedge clk);
    prev = m_st;
    m_st = next_st(m_st, |t, a, b);
    m_seen = (m_seen & ~c) | t;
    #1;
    if (prev == M_REC && (|t)) chk("R6 trip in recovery re-pulls", {2'b0, pd_o}, 3'b001);
    else if (|t) chk("R3 pull after trip", {2'b0, pd_o}, 3'b001);
    else chk("R4 pull-down state", {2'b0, pd_o}, {2'b0, m_st == M_PULL});
    chk(((c & t) != 0) ? "R10 set wins over clear" : "R9 R10 trip record", seen_o, m_seen);
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    hi_cmd = '1; lo_cmd = '1;
    #12;
    chk("R1 reset gates hi", hi_o, '0);
    chk("R1 reset gates lo", lo_o, '0);
    chk("R1 reset pull", {2'b0, pd_o}, '0);
    chk("R1 reset record", seen_o, '0);
    @(negedge clk); rst_n = 1'b1;
    m_st = M_REC; m_seen = '0;
    // directed: stay off until above, then run
    step('0, 0, 0, 3'b101, 3'b010, '0);
    step('0, 0, 0, 3'b101, 3'b010, '0);
    step('0, 1, 0, 3'b101, 3'b010, '0);
    step('0, 0, 0, 3'b110, 3'b001, '0);
    // trip on leg 1, hold until below
    step(3'b010, 0, 0, 3'b111, 3'b111, '0);
    step('0, 1, 0, 3'b111, 3'b111, '0);
    step('0, 0, 1, 3'b111, 3'b111, '0);
    step('0, 0, 0, 3'b111, 3'b111, '0);
    // trip during recovery, then release and recover
    step(3'b100, 0, 0, 3'b111, 3'b111, 3'b010);
    step('0, 0, 1, 3'b111, 3'b111, '0);
    step('0, 1, 0, 3'b011, 3'b100, '0);
    // external shutdown while running
    step('0, 0, 1, 3'b011, 3'b100, '0);
    step('0, 1, 0, 3'b011, 3'b100, '0);
    // set and clear on same edge
    step(3'b001, 0, 0, '0, '0, 3'b001);
    step('0, 0, 0, '0, '0, 3'b111);
    for (int n = 0; n < 3000; n++) begin
      logic [L-1:0] t, c;
      int r;
      logic a, b;
      for (int k = 0; k < L; k++) begin
        t[k] = ($urandom % 24) == 0;
        c[k] = ($urandom % 6) == 0;
      end
      r = $urandom % 10;
      a = (r < 3); b = (r == 3 || r == 4);
      step(t, a, b, L'($urandom), L'($urandom), c);
    end
    // reset in the middle of operation
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 mid reset pull", {2'b0, pd_o}, '0);
    chk("R1 mid reset record", seen_o, '0);
    chk("R1 mid reset gates", hi_o | lo_o, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule